// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the state of a small bank of interrupt sources and decides when each one is offered to a downstream presentation controller. Each source has a configured priority, a target server number and a type flag. The type flag selects between a message source and a level source. At run time each source also carries a two-bit state with a presented bit and a queued bit, a resend flag and a masked-pending flag.

Four kinds of request reach the block: source triggers, end-of-interrupt (EOI) commands naming a source, rejected sources handed back by the presenter, and requests to scan the resend flags. One arbiter serialises them. A source that qualifies is offered on a valid/ready delivery port, and at most one offer is outstanding at a time. The presenter then answers with accept or refuse. A refused source is marked for resend and replayed by a later scan, so it is never dropped. A source at the masked priority is never offered; it only records that it was wanted.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset every source has priority 0xFF (masked), a two-bit state of 0, and clear resend and masked-pending flags. No delivery is offered and the scan is idle.
- R2: A trigger on a message source sets the two-bit state to ((old << 1) & 3) | 1. Bit 0 is presented and bit 1 is queued. A delivery is attempted only when the result is exactly 2'b01.
- R3: An EOI on a message source shifts the state right by one, which moves queued into presented. A delivery is attempted if presented is then set.
- R4: A trigger on a level source copies the trigger's level into the presented bit. A delivery is attempted only when presented goes from 0 to 1.
- R5: An EOI on a level source leaves the state unchanged and attempts a delivery if presented is still set.
- R6: An attempt on a source whose priority is 0xFF offers nothing and sets that source's masked-pending bit. This holds for first deliveries, rejects and resends alike. Masked-pending bits only clear on reset.
- R7: When the presenter refuses an offer, the source's resend flag is set and resend_note_o pulses high for one cycle, in the cycle after the refusal.
- R8: A scan walks every source in index order and attempts delivery only where the resend flag is set. Every attempt clears that flag, so a second scan with no new refusals offers nothing.
- R9: A rejected source handed back by the presenter gets a normal delivery attempt with its current priority and server.
- R10: When the block is idle, requests are granted with the precedence EOI, then reject, then trigger, then scan step. A ready output is high only in the cycle its request is taken.
- R11: At most one delivery is outstanding. While dlv_valid_o is high no request is granted, and while dlv_ready_i is low the offer and its payload hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write configuration of one source |
| cfg_src_i | input | SRC_W | Source to configure |
| cfg_prio_i | input | PRIO_W | Priority (0xFF = masked, lower = more favoured) |
| cfg_srv_i | input | SRV_W | Target server number |
| cfg_lsi_i | input | 1 | 1 = level source, 0 = message source |
| trig_valid_i | input | 1 | Trigger request |
| trig_ready_o | output | 1 | Trigger taken |
| trig_src_i | input | SRC_W | Triggered source |
| trig_level_i | input | 1 | Line level for level sources, ignored otherwise |
| eoi_valid_i | input | 1 | EOI request |
| eoi_ready_o | output | 1 | EOI taken |
| eoi_src_i | input | SRC_W | Source being ended |
| rej_valid_i | input | 1 | Rejected source returned by presenter |
| rej_ready_o | output | 1 | Reject taken |
| rej_src_i | input | SRC_W | Rejected source |
| scan_req_i | input | 1 | Start (or restart) a resend scan |
| scan_busy_o | output | 1 | Scan in progress |
| dlv_valid_o | output | 1 | Delivery offer valid |
| dlv_ready_i | input | 1 | Presenter takes the offer |
| dlv_src_o | output | SRC_W | Offered source |
| dlv_prio_o | output | PRIO_W | Offered priority |
| dlv_srv_o | output | SRV_W | Offered server |
| rsp_valid_i | input | 1 | Presenter result valid |
| rsp_accept_i | input | 1 | 1 = accepted, 0 = refused |
| resend_note_o | output | 1 | Pulse: a resend is now waiting |
| masked_pend_o | output | NUM_SRC | Masked-pending flag per source |

## Verification
The bench pushes a message source through every two-bit state. If a design forced presented without shifting, or offered on any set presented bit, it would deliver a second time while an interrupt is in flight, or fail to deliver the queued one on EOI. It then refuses offers and runs two scans back to back. A design that forgets the resend flag loses the interrupt, and one that never clears the flag replays it again on the second scan. One source is masked after its refusal, which checks that a masked resend sets masked-pending and is not offered. Level sources, the hold of a stalled offer, and a three-way request collision that exposes a wrong precedence order are also driven against the reference model.

// File: rtl/isc_pkg.sv
`timescale 1ns/1ps
package isc_pkg;
  typedef enum logic [2:0] {OP_NONE, OP_EOI, OP_REJ, OP_TRG, OP_SCN} op_e;
  typedef enum logic [1:0] {DS_IDLE, DS_REQ, DS_WAIT} dlv_st_e;
endpackage

// File: rtl/isc_arb.sv
`timescale 1ns/1ps
module isc_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic eoi_v_i,
  input  logic rej_v_i,
  input  logic trg_v_i,
  input  logic scn_v_i,
  output logic eoi_g_o,
  output logic rej_g_o,
  output logic trg_g_o,
  output logic scn_g_o
);
  always_comb begin
    eoi_g_o = idle_i & eoi_v_i;
    rej_g_o = idle_i & ~eoi_v_i & rej_v_i;
    trg_g_o = idle_i & ~eoi_v_i & ~rej_v_i & trg_v_i;
    scn_g_o = idle_i & ~eoi_v_i & ~rej_v_i & ~trg_v_i & scn_v_i;
  end

  // R10
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({eoi_g_o, rej_g_o, trg_g_o, scn_g_o}));
  // R10
  trig_prec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trg_g_o |-> (!eoi_v_i && !rej_v_i));
endmodule

// File: rtl/isc_src_bank.sv
`timescale 1ns/1ps
module isc_src_bank
  import isc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 8,
  parameter int SRV_W   = 4,
  parameter int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [SRC_W-1:0]   cfg_src_i,
  input  logic [PRIO_W-1:0]  cfg_prio_i,
  input  logic [SRV_W-1:0]   cfg_srv_i,
  input  logic               cfg_lsi_i,
  input  op_e                op_i,
  input  logic [SRC_W-1:0]   op_src_i,
  input  logic               op_lvl_i,
  input  logic               scan_req_i,
  output logic               scan_act_o,
  input  logic               refuse_i,
  input  logic [SRC_W-1:0]   refuse_src_i,
  output logic               att_o,
  output logic [SRC_W-1:0]   att_src_o,
  output logic [PRIO_W-1:0]  att_prio_o,
  output logic [SRV_W-1:0]   att_srv_o,
  output logic [NUM_SRC-1:0] mpend_o
);
  localparam logic [PRIO_W-1:0] MASKED = '1;
  localparam logic [SRC_W-1:0]  LAST   = SRC_W'(NUM_SRC - 1);

  logic [NUM_SRC-1:0][1:0]        pq_all;
  logic [NUM_SRC-1:0]             rs_all, lsi_all;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_all;
  logic [NUM_SRC-1:0][SRV_W-1:0]  srv_all;

  logic [SRC_W-1:0]  sel, ptr_q;
  logic              scan_q;
  logic [1:0]        pq_c, pq_nx;
  logic              want, masked;

  assign sel    = (op_i == OP_SCN) ? ptr_q : op_src_i;
  assign pq_c   = pq_all[sel];
  assign masked = (prio_all[sel] == MASKED);

  always_comb begin
    pq_nx = pq_c;
    want  = 1'b0;
    unique case (op_i)
      OP_EOI: begin
        if (!lsi_all[sel]) pq_nx = {1'b0, pq_c[1]};
        want = pq_nx[0];
      end
      OP_TRG: begin
        if (lsi_all[sel]) begin
          pq_nx = {pq_c[1], op_lvl_i};
          want  = op_lvl_i & ~pq_c[0];
        end else begin
          pq_nx = {pq_c[0], 1'b1};
          want  = (pq_nx == 2'b01);
        end
      end
      OP_REJ:  want = 1'b1;
      OP_SCN:  want = rs_all[sel];
      default: want = 1'b0;
    endcase
  end

  assign att_o      = want & ~masked;
  assign att_src_o  = sel;
  assign att_prio_o = prio_all[sel];
  assign att_srv_o  = srv_all[sel];
  assign mpend_o    = mpend_w;

  logic [NUM_SRC-1:0] mpend_w;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [1:0]        pq_r;
    logic              rs_r, mp_r, lsi_r;
    logic [PRIO_W-1:0] prio_r;
    logic [SRV_W-1:0]  srv_r;
    logic              hit;

    assign hit = (op_i != OP_NONE) && (sel == SRC_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pq_r   <= 2'b00;
        rs_r   <= 1'b0;
        mp_r   <= 1'b0;
        lsi_r  <= 1'b0;
        prio_r <= MASKED;
        srv_r  <= '0;
      end else begin
        if (cfg_we_i && cfg_src_i == SRC_W'(g)) begin
          prio_r <= cfg_prio_i;
          srv_r  <= cfg_srv_i;
          lsi_r  <= cfg_lsi_i;
        end
        if (hit) begin
          pq_r <= pq_nx;
          if (want) rs_r <= 1'b0;
          if (want && masked) mp_r <= 1'b1;
        end
        if (refuse_i && refuse_src_i == SRC_W'(g)) rs_r <= 1'b1;
      end
    end

    assign pq_all[g]   = pq_r;
    assign rs_all[g]   = rs_r;
    assign lsi_all[g]  = lsi_r;
    assign prio_all[g] = prio_r;
    assign srv_all[g]  = srv_r;
    assign mpend_w[g]  = mp_r;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_q <= 1'b0;
      ptr_q  <= '0;
    end else if (scan_req_i) begin
      scan_q <= 1'b1;
      ptr_q  <= '0;
    end else if (op_i == OP_SCN) begin
      ptr_q <= ptr_q + 1'b1;
      if (ptr_q == LAST) scan_q <= 1'b0;
    end
  end

  assign scan_act_o = scan_q;

  // R6
  mpend_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(mpend_w) & ~mpend_w) == '0));
  // R8
  scan_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SCN) |-> scan_q);
endmodule

// File: rtl/isc_dlv.sv
`timescale 1ns/1ps
module isc_dlv
  import isc_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int SRV_W  = 4,
  parameter int SRC_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              att_i,
  input  logic [SRC_W-1:0]  att_src_i,
  input  logic [PRIO_W-1:0] att_prio_i,
  input  logic [SRV_W-1:0]  att_srv_i,
  output logic              idle_o,
  output logic              dlv_valid_o,
  input  logic              dlv_ready_i,
  output logic [SRC_W-1:0]  dlv_src_o,
  output logic [PRIO_W-1:0] dlv_prio_o,
  output logic [SRV_W-1:0]  dlv_srv_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_accept_i,
  output logic              refuse_o,
  output logic              resend_note_o
);
  localparam logic [PRIO_W-1:0] MASKED = '1;

  dlv_st_e st_q;
  logic    note_q;

  assign idle_o      = (st_q == DS_IDLE);
  assign dlv_valid_o = (st_q == DS_REQ);
  assign refuse_o    = (st_q == DS_WAIT) && rsp_valid_i && !rsp_accept_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= DS_IDLE;
      dlv_src_o  <= '0;
      dlv_prio_o <= '0;
      dlv_srv_o  <= '0;
      note_q     <= 1'b0;
    end else begin
      note_q <= refuse_o;
      unique case (st_q)
        DS_IDLE: if (att_i) begin
          st_q       <= DS_REQ;
          dlv_src_o  <= att_src_i;
          dlv_prio_o <= att_prio_i;
          dlv_srv_o  <= att_srv_i;
        end
        DS_REQ:  if (dlv_ready_i) st_q <= DS_WAIT;
        DS_WAIT: if (rsp_valid_i) st_q <= DS_IDLE;
        default: st_q <= DS_IDLE;
      endcase
    end
  end

  assign resend_note_o = note_q;

  // R11
  offer_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_valid_o && !dlv_ready_i) |=> (dlv_valid_o && $stable(dlv_src_o)
      && $stable(dlv_prio_o) && $stable(dlv_srv_o)));
  // R6
  no_masked_offer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o |-> (dlv_prio_o != MASKED));
  // R7
  note_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resend_note_o |-> $past(rsp_valid_i && !rsp_accept_i));
endmodule

// File: rtl/irq_src_ctrl.sv
`timescale 1ns/1ps
module irq_src_ctrl
  import isc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 8,
  parameter int SRV_W   = 4,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [SRC_W-1:0]   cfg_src_i,
  input  logic [PRIO_W-1:0]  cfg_prio_i,
  input  logic [SRV_W-1:0]   cfg_srv_i,
  input  logic               cfg_lsi_i,
  input  logic               trig_valid_i,
  output logic               trig_ready_o,
  input  logic [SRC_W-1:0]   trig_src_i,
  input  logic               trig_level_i,
  input  logic               eoi_valid_i,
  output logic               eoi_ready_o,
  input  logic [SRC_W-1:0]   eoi_src_i,
  input  logic               rej_valid_i,
  output logic               rej_ready_o,
  input  logic [SRC_W-1:0]   rej_src_i,
  input  logic               scan_req_i,
  output logic               scan_busy_o,
  output logic               dlv_valid_o,
  input  logic               dlv_ready_i,
  output logic [SRC_W-1:0]   dlv_src_o,
  output logic [PRIO_W-1:0]  dlv_prio_o,
  output logic [SRV_W-1:0]   dlv_srv_o,
  input  logic               rsp_valid_i,
  input  logic               rsp_accept_i,
  output logic               resend_note_o,
  output logic [NUM_SRC-1:0] masked_pend_o
);
  logic              idle, scan_act, g_eoi, g_rej, g_trg, g_scn;
  logic              att, refuse;
  logic [SRC_W-1:0]  att_src, op_src;
  logic [PRIO_W-1:0] att_prio;
  logic [SRV_W-1:0]  att_srv;
  op_e               op;

  isc_arb u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idle_i  (idle),
    .eoi_v_i (eoi_valid_i),
    .rej_v_i (rej_valid_i),
    .trg_v_i (trig_valid_i),
    .scn_v_i (scan_act),
    .eoi_g_o (g_eoi),
    .rej_g_o (g_rej),
    .trg_g_o (g_trg),
    .scn_g_o (g_scn)
  );

  always_comb begin
    op     = OP_NONE;
    op_src = trig_src_i;
    if (g_eoi) begin
      op = OP_EOI; op_src = eoi_src_i;
    end else if (g_rej) begin
      op = OP_REJ; op_src = rej_src_i;
    end else if (g_trg) begin
      op = OP_TRG;
    end else if (g_scn) begin
      op = OP_SCN;
    end
  end

  isc_src_bank #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .SRV_W   (SRV_W),
    .SRC_W   (SRC_W)
  ) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_we_i     (cfg_we_i),
    .cfg_src_i    (cfg_src_i),
    .cfg_prio_i   (cfg_prio_i),
    .cfg_srv_i    (cfg_srv_i),
    .cfg_lsi_i    (cfg_lsi_i),
    .op_i         (op),
    .op_src_i     (op_src),
    .op_lvl_i     (trig_level_i),
    .scan_req_i   (scan_req_i),
    .scan_act_o   (scan_act),
    .refuse_i     (refuse),
    .refuse_src_i (dlv_src_o),
    .att_o        (att),
    .att_src_o    (att_src),
    .att_prio_o   (att_prio),
    .att_srv_o    (att_srv),
    .mpend_o      (masked_pend_o)
  );

  isc_dlv #(
    .PRIO_W (PRIO_W),
    .SRV_W  (SRV_W),
    .SRC_W  (SRC_W)
  ) u_dlv (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .att_i         (att),
    .att_src_i     (att_src),
    .att_prio_i    (att_prio),
    .att_srv_i     (att_srv),
    .idle_o        (idle),
    .dlv_valid_o   (dlv_valid_o),
    .dlv_ready_i   (dlv_ready_i),
    .dlv_src_o     (dlv_src_o),
    .dlv_prio_o    (dlv_prio_o),
    .dlv_srv_o     (dlv_srv_o),
    .rsp_valid_i   (rsp_valid_i),
    .rsp_accept_i  (rsp_accept_i),
    .refuse_o      (refuse),
    .resend_note_o (resend_note_o)
  );

  assign trig_ready_o = g_trg;
  assign eoi_ready_o  = g_eoi;
  assign rej_ready_o  = g_rej;
  assign scan_busy_o  = scan_act;

  // R11
  single_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o |-> !(trig_ready_o || eoi_ready_o || rej_ready_o));
endmodule

// File: tb/irq_src_ctrl_tb.sv
`timescale 1ns/1ps
module irq_src_ctrl_tb;
  localparam int N  = 8;
  localparam int SW = 3;
  localparam int PW = 8;
  localparam int VW = 4;
  localparam logic [PW-1:0] MASK = 8'hFF;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cfg_we = 0, cfg_lsi = 0;
  logic [SW-1:0] cfg_src = 0, trig_src = 0, eoi_src = 0, rej_src = 0;
  logic [PW-1:0] cfg_prio = 0;
  logic [VW-1:0] cfg_srv = 0;
  logic trig_valid = 0, trig_level = 0, eoi_valid = 0, rej_valid = 0, scan_req = 0;
  logic dlv_ready = 1, rsp_valid = 0, rsp_accept = 0;
  logic trig_ready_o, eoi_ready_o, rej_ready_o, scan_busy_o, dlv_valid_o, resend_note_o;
  logic [SW-1:0] dlv_src_o;
  logic [PW-1:0] dlv_prio_o;
  logic [VW-1:0] dlv_srv_o;
  logic [N-1:0]  masked_pend_o;

  always #10 clk_i = ~clk_i;

  irq_src_ctrl #(.NUM_SRC(N), .PRIO_W(PW), .SRV_W(VW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_src_i(cfg_src), .cfg_prio_i(cfg_prio),
    .cfg_srv_i(cfg_srv), .cfg_lsi_i(cfg_lsi),
    .trig_valid_i(trig_valid), .trig_ready_o(trig_ready_o),
    .trig_src_i(trig_src), .trig_level_i(trig_level),
    .eoi_valid_i(eoi_valid), .eoi_ready_o(eoi_ready_o), .eoi_src_i(eoi_src),
    .rej_valid_i(rej_valid), .rej_ready_o(rej_ready_o), .rej_src_i(rej_src),
    .scan_req_i(scan_req), .scan_busy_o(scan_busy_o),
    .dlv_valid_o(dlv_valid_o), .dlv_ready_i(dlv_ready),
    .dlv_src_o(dlv_src_o), .dlv_prio_o(dlv_prio_o), .dlv_srv_o(dlv_srv_o),
    .rsp_valid_i(rsp_valid), .rsp_accept_i(rsp_accept),
    .resend_note_o(resend_note_o), .masked_pend_o(masked_pend_o)
  );

  int n_chk = 0, n_fail = 0;
  bit may_dlv = 0, cmp_en = 0;

  // reference model
  logic [1:0]    m_pq  [N];
  logic          m_rs  [N];
  logic          m_lsi [N];
  logic [PW-1:0] m_pr  [N];
  logic [VW-1:0] m_sv  [N];
  logic [N-1:0]  m_mp;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      #2;
      if (cmp_en) chk("R6 masked_pend_o", 32'(masked_pend_o), 32'(m_mp));
      if (dlv_valid_o && !may_dlv) chk("R11 unexpected offer", 1, 0);
    end
  end

  function automatic bit m_attempt(input int s);
    m_rs[s] = 1'b0;
    if (m_pr[s] == MASK) begin
      m_mp[s] = 1'b1;
      return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic cfg(input int s, input logic [PW-1:0] p, input logic [VW-1:0] v, input bit l);
    @(negedge clk_i);
    cfg_we = 1; cfg_src = SW'(s); cfg_prio = p; cfg_srv = v; cfg_lsi = l;
    @(negedge clk_i);
    cfg_we = 0;
    m_pr[s] = p; m_sv[s] = v; m_lsi[s] = l;
  endtask

  // called at the negedge where the offer should already be up
  task automatic exp_dlv(input int s, input bit acc, input string req);
    for (int k = 0; k < 20 && !dlv_valid_o; k++) @(negedge clk_i);
    chk({req, " offer valid"}, 32'(dlv_valid_o), 1);
    chk({req, " src"}, 32'(dlv_src_o), 32'(s));
    chk({req, " prio"}, 32'(dlv_prio_o), 32'(m_pr[s]));
    chk({req, " server"}, 32'(dlv_srv_o), 32'(m_sv[s]));
    @(negedge clk_i);
    rsp_valid = 1; rsp_accept = acc;
    @(negedge clk_i);
    rsp_valid = 0;
    chk("R7 resend_note_o", 32'(resend_note_o), 32'(!acc));
    if (!acc) m_rs[s] = 1'b1;
    may_dlv = 0;
  endtask

  // kind: 0 trigger, 1 eoi, 2 reject
  task automatic op(input int kind, input int s, input bit lvl, input bit acc, input string req);
    bit want, att;
    @(negedge clk_i);
    case (kind)
      0: begin trig_valid = 1; trig_src = SW'(s); trig_level = lvl; end
      1: begin eoi_valid = 1; eoi_src = SW'(s); end
      default: begin rej_valid = 1; rej_src = SW'(s); end
    endcase
    #1;
    case (kind)
      0: chk("R10 trig_ready_o", 32'(trig_ready_o), 1);
      1: chk("R10 eoi_ready_o", 32'(eoi_ready_o), 1);
      default: chk("R10 rej_ready_o", 32'(rej_ready_o), 1);
    endcase
    @(negedge clk_i);
    trig_valid = 0; eoi_valid = 0; rej_valid = 0;
    want = 0;
    case (kind)
      0: if (m_lsi[s]) begin
           want = lvl && !m_pq[s][0];
           m_pq[s][0] = lvl;
         end else begin
           m_pq[s] = ((m_pq[s] << 1) & 2'b11) | 2'b01;
           want = (m_pq[s] == 2'b01);
         end
      1: begin
           if (!m_lsi[s]) m_pq[s] = m_pq[s] >> 1;
           want = m_pq[s][0];
         end
      default: want = 1;
    endcase
    att = want ? m_attempt(s) : 1'b0;
    if (att) begin
      may_dlv = 1;
      exp_dlv(s, acc, req);
    end else begin
      chk({req, " no offer"}, 32'(dlv_valid_o), 0);
      @(negedge clk_i);
      chk({req, " no offer later"}, 32'(dlv_valid_o), 0);
    end
  endtask

  task automatic scan(input bit acc, input string req);
    int q[$];
    for (int p = 0; p < N; p++)
      if (m_rs[p]) begin
        if (m_pr[p] == MASK) begin m_mp[p] = 1; m_rs[p] = 0; end
        else q.push_back(p);
      end
    cmp_en = 0;
    @(negedge clk_i);
    scan_req = 1;
    @(negedge clk_i);
    scan_req = 0;
    chk({req, " scan_busy_o"}, 32'(scan_busy_o), 1);
    foreach (q[i]) begin
      m_rs[q[i]] = 0;
      may_dlv = 1;
      exp_dlv(q[i], acc, req);
    end
    may_dlv = 0;
    for (int k = 0; k < 40 && scan_busy_o; k++) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    chk({req, " scan finished"}, 32'(scan_busy_o), 0);
    chk({req, " no extra offer"}, 32'(dlv_valid_o), 0);
    cmp_en = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_pq[i] = 0; m_rs[i] = 0; m_lsi[i] = 0; m_pr[i] = MASK; m_sv[i] = 0;
    end
    m_mp = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 masked_pend_o", 32'(masked_pend_o), 0);
    chk("R1 dlv_valid_o", 32'(dlv_valid_o), 0);
    chk("R1 scan_busy_o", 32'(scan_busy_o), 0);
    chk("R1 resend_note_o", 32'(resend_note_o), 0);
    cmp_en = 1;
    // R1 default priority is masked
    op(0, 5, 0, 1, "R1 unconfigured trigger");
    chk("R1 masked bit 5", 32'(masked_pend_o[5]), 1);

    cfg(0, 8'd3, 4'd2, 0);
    cfg(1, 8'd5, 4'd1, 0);
    cfg(2, 8'd4, 4'd3, 1);
    cfg(3, 8'd7, 4'd0, 0);

    // R2 message trigger states
    op(0, 0, 0, 1, "R2 trig 00->01");
    op(0, 0, 0, 1, "R2 trig 01->11");
    op(0, 0, 0, 1, "R2 trig 11->11");
    // R3 message eoi
    op(1, 0, 0, 1, "R3 eoi 11->01");
    op(1, 0, 0, 1, "R3 eoi 01->00");

    // R4 / R5 level source
    op(0, 2, 1, 1, "R4 level rise");
    op(0, 2, 1, 1, "R4 level held");
    op(1, 2, 0, 1, "R5 eoi level high");
    op(0, 2, 0, 1, "R4 level fall");
    op(1, 2, 0, 1, "R5 eoi level low");

    // R7 refusals
    op(0, 1, 0, 0, "R7 refuse src1");
    op(0, 3, 0, 0, "R7 refuse src3");
    cfg(3, MASK, 4'd0, 0);
    // R8 / R6 scans
    scan(1, "R8 first scan");
    chk("R6 masked resend src3", 32'(masked_pend_o[3]), 1);
    scan(1, "R8 second scan");

    // R9 reject uses current config
    cfg(0, 8'd2, 4'd5, 0);
    op(2, 0, 0, 1, "R9 reject src0");

    // R11 stalled offer
    @(negedge clk_i);
    rej_valid = 1; rej_src = 3'd1; dlv_ready = 0;
    @(negedge clk_i);
    rej_valid = 0;
    void'(m_attempt(1));
    may_dlv = 1;
    chk("R11 offer up", 32'(dlv_valid_o), 1);
    trig_valid = 1; trig_src = 3'd0;
    #1;
    chk("R11 trig blocked", 32'(trig_ready_o), 0);
    trig_valid = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk("R11 offer held", 32'(dlv_valid_o), 1);
      chk("R11 src held", 32'(dlv_src_o), 1);
    end
    dlv_ready = 1;
    exp_dlv(1, 1, "R11 stalled offer");

    // R10 precedence collision (src0 pq=00, src6/src7 masked)
    @(negedge clk_i);
    eoi_valid = 1; eoi_src = 3'd0;
    rej_valid = 1; rej_src = 3'd6;
    trig_valid = 1; trig_src = 3'd7;
    #1;
    chk("R10 eoi first", 32'({eoi_ready_o, rej_ready_o, trig_ready_o}), 32'b100);
    @(negedge clk_i);
    eoi_valid = 0;
    #1;
    chk("R10 reject second", 32'({eoi_ready_o, rej_ready_o, trig_ready_o}), 32'b010);
    @(negedge clk_i);
    rej_valid = 0;
    void'(m_attempt(6));
    #1;
    chk("R10 trigger third", 32'({eoi_ready_o, rej_ready_o, trig_ready_o}), 32'b001);
    @(negedge clk_i);
    trig_valid = 0;
    m_pq[7] = 2'b01;
    void'(m_attempt(7));
    @(negedge clk_i);
    chk("R10 no offer", 32'(dlv_valid_o), 0);
    chk("R6 masked 6 and 7", 32'(masked_pend_o[7:6]), 32'b11);
    repeat (3) @(negedge clk_i);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule